// File: doc/BRIEF.md
# Fixed-Point PD Balance Controller

This block turns a stream of tilt-angle samples into a signed motor correction command. Each sample arrives as two unsigned bytes, a whole-degree part and a hundredths part, together with a one-cycle valid strobe. The block scales the angle to hundredths of a degree by multiplying the whole part by 100 and adding the hundredths, so no division is needed. It subtracts a setpoint to form a signed error. It then adds a proportional term (error times one gain) and a derivative term (the change in error since the previous sample, times a second gain).

The sum is clamped to a signed command width and registered. It appears one cycle after the strobe, together with a one-cycle output strobe. The command is also offered in a form ready for a PWM stage: a direction bit taken from its sign, and a magnitude clamped to the PWM full-scale count. Both gains and the setpoint are run-time inputs. They are read only on a strobe cycle, and the derivative state moves only when a sample arrives.

Top module: `pd_balance`

## Requirements
- R1: The scaled angle equals `ang_int`×100 + `ang_frac`, where both inputs are 8-bit unsigned values; `ang_frac` is not clamped, so the full range is 0 to 25,755.
- R2: The error equals the scaled angle minus the 15-bit unsigned `setpoint`, taken as a signed value.
- R3: The proportional term equals error × `kp`, with `kp` an 8-bit unsigned gain.
- R4: The derivative term equals (error − previous error) × `kd`, with `kd` an 8-bit unsigned gain. The previous error is loaded with the current error on every strobe cycle.
- R5: On the first strobe after reset, the derivative term is zero.
- R6: `cmd_out` equals proportional plus derivative, saturated to the signed range −32768 to 32767. It is updated at the clock edge that samples `sample_valid` high, and `cmd_valid` is high for exactly the following cycle.
- R7: Without `sample_valid`, changes on the angle, setpoint and gain inputs leave `cmd_out`, `dir_out` and `mag_out` unchanged. A gain change first affects the sample it is presented with.
- R8: `dir_out` is 1 exactly when `cmd_out` is negative. `mag_out` equals |`cmd_out`| clamped to `PWM_FULL` (default 1000).
- R9: After reset, `cmd_out`, `cmd_valid`, `dir_out` and `mag_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_valid | input | 1 | One-cycle strobe marking a new angle sample |
| ang_int | input | 8 | Whole-degree part of the angle, unsigned |
| ang_frac | input | 8 | Hundredths part of the angle, unsigned |
| setpoint | input | 15 | Target angle in hundredths, unsigned |
| kp | input | GAIN_W | Proportional gain, unsigned |
| kd | input | GAIN_W | Derivative gain, unsigned |
| cmd_out | output | CMD_W | Saturated signed correction command |
| cmd_valid | output | 1 | High the cycle after a sample is taken |
| dir_out | output | 1 | Sign of the command (1 = negative) |
| mag_out | output | MAG_W | Command magnitude clamped to PWM_FULL |

## Verification
Saturation and the derivative kick can fall in the same sample. A large error step at high `kd`, added to a large proportional term, drives the sum past the command range even when either term alone would fit. The bench provokes this by alternating between extreme angles with both gains at maximum. It judges the result against an arithmetic model that adds both terms in wide integers before clamping. The magnitude clamp is judged on the same samples, because saturation and the PWM full-scale limit are then both active.

// File: rtl/pd_balance.sv
module pd_balance #(
  parameter int GAIN_W   = 8,
  parameter int CMD_W    = 16,
  parameter int PWM_FULL = 1000,
  localparam int MAG_W   = $clog2(PWM_FULL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_valid,
  input  logic [7:0]        ang_int,
  input  logic [7:0]        ang_frac,
  input  logic [14:0]       setpoint,
  input  logic [GAIN_W-1:0] kp,
  input  logic [GAIN_W-1:0] kd,
  output logic [CMD_W-1:0]  cmd_out,
  output logic              cmd_valid,
  output logic              dir_out,
  output logic [MAG_W-1:0]  mag_out
);
  localparam int ANG_W = 15;
  localparam int ERR_W = ANG_W + 1;
  localparam int DIF_W = ERR_W + 1;
  localparam int P_W   = ERR_W + GAIN_W + 1;
  localparam int D_W   = DIF_W + GAIN_W + 1;
  localparam int SUM_W = D_W + 1;
  localparam logic signed [SUM_W-1:0] CMAX = SUM_W'((64'sd1 <<< (CMD_W - 1)) - 64'sd1);
  localparam logic signed [SUM_W-1:0] CMIN = -CMAX - SUM_W'(1);
  localparam logic [CMD_W:0] FULL_C = (CMD_W + 1)'(PWM_FULL);

  typedef enum logic {WAIT_FIRST, TRACK} dstate_t;
  dstate_t dstate;

  logic [ANG_W-1:0]        ang;
  logic signed [ERR_W-1:0] err, prev_err;
  logic signed [DIF_W-1:0] diff;
  logic signed [P_W-1:0]   pterm;
  logic signed [D_W-1:0]   dterm;
  logic signed [SUM_W-1:0] sum;
  logic [CMD_W-1:0]        cmd_next;
  logic [CMD_W:0]          cmd_abs;

  assign ang   = ANG_W'(ang_int) * ANG_W'(100) + ANG_W'(ang_frac);
  assign err   = $signed({1'b0, ang}) - $signed({1'b0, setpoint});
  assign diff  = (dstate == TRACK) ? (DIF_W'(err) - DIF_W'(prev_err)) : '0;
  assign pterm = P_W'(err) * P_W'($signed({1'b0, kp}));
  assign dterm = D_W'(diff) * D_W'($signed({1'b0, kd}));
  assign sum   = SUM_W'(pterm) + SUM_W'(dterm);

  always_comb begin
    if (sum > CMAX)      cmd_next = CMAX[CMD_W-1:0];
    else if (sum < CMIN) cmd_next = CMIN[CMD_W-1:0];
    else                 cmd_next = sum[CMD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_out   <= '0;
      cmd_valid <= 1'b0;
      prev_err  <= '0;
      dstate    <= WAIT_FIRST;
    end else begin
      cmd_valid <= sample_valid;
      if (sample_valid) begin
        cmd_out  <= cmd_next;
        prev_err <= err;
        dstate   <= TRACK;
      end
    end
  end

  assign dir_out = cmd_out[CMD_W-1];
  assign cmd_abs = dir_out ? ((CMD_W + 1)'(0) - {1'b1, cmd_out}) : {1'b0, cmd_out};
  assign mag_out = (cmd_abs > FULL_C) ? MAG_W'(PWM_FULL) : cmd_abs[MAG_W-1:0];

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> $stable(cmd_out)); // R7
  AST_MAG_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (CMD_W + 1)'(mag_out) <= FULL_C); // R8
  AST_ZERO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_out == '0) |-> (mag_out == '0 && !dir_out)); // R8
  AST_MAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_out && {1'b0, cmd_out} <= FULL_C) |-> ((CMD_W + 1)'(mag_out) == {1'b0, cmd_out})); // R8
  AST_VALID_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid || $past(sample_valid)); // R6
endmodule

// File: tb/pd_balance_bench.sv
module pd_balance_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FULL = 1000;

  logic clk = 0, rst_n = 0, sample_valid = 0;
  logic [7:0] ang_int = 0, ang_frac = 0, kp = 0, kd = 0;
  logic [14:0] setpoint = 0;
  logic [15:0] cmd_out;
  logic cmd_valid, dir_out;
  logic [9:0] mag_out;

  int vectors = 0, fails = 0, cycles = 0;
  bit first = 1;
  longint prev = 0;
  longint exp_cmd = 0;

  pd_balance u_pd_balance (.clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
    .ang_int(ang_int), .ang_frac(ang_frac), .setpoint(setpoint), .kp(kp), .kd(kd),
    .cmd_out(cmd_out), .cmd_valid(cmd_valid), .dir_out(dir_out), .mag_out(mag_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, string what, longint act, longint expv);
    vectors++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; sample_valid = 0;
    @(negedge clk); rst_n = 1;
    first = 1; prev = 0; exp_cmd = 0;
  endtask

  task automatic apply(string req, int i, int f, int sp, int p, int d);
    longint err, s, a;
    @(negedge clk);
    ang_int = 8'(i); ang_frac = 8'(f); setpoint = 15'(sp); kp = 8'(p); kd = 8'(d);
    sample_valid = 1;
    err = longint'(i) * 100 + f - sp;
    s = err * p + (first ? 0 : (err - prev) * d);
    first = 0; prev = err;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    exp_cmd = s;
    @(negedge clk);
    sample_valid = 0;
    a = (s < 0) ? -s : s;
    if (a > FULL) a = FULL;
    check(req, "cmd", longint'($signed(cmd_out)), s);
    check("R6", "cmd_valid", longint'(cmd_valid), 1);
    check("R8", "dir", longint'(dir_out), (s < 0) ? 1 : 0);
    check("R8", "mag", longint'(mag_out), a);
  endtask

  task automatic idle_poke();
    @(negedge clk);
    ang_int = ~ang_int; kp = ~kp; kd = kd + 8'd77; setpoint = ~setpoint;
    @(negedge clk);
    check("R6", "valid low when idle", longint'(cmd_valid), 0);
    check("R7", "cmd held", longint'($signed(cmd_out)), exp_cmd);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD/4);
    check("R9", "cmd at reset", longint'(cmd_out), 0);
    check("R9", "valid at reset", longint'(cmd_valid), 0);
    check("R9", "dir at reset", longint'(dir_out), 0);
    check("R9", "mag at reset", longint'(mag_out), 0);
    do_reset();
    // R1: composition with unit gain, no setpoint, no derivative
    for (int i = 0; i < 256; i += 5)
      for (int f = 0; f < 256; f += 17) apply("R1", i, f, 0, 1, 0);
    // R2: setpoint sweep
    for (int sp = 0; sp < 32768; sp += 1531) apply("R2", 123, 45, sp, 1, 0);
    // R3: proportional gain sweep
    for (int p = 0; p < 256; p++) apply("R3", 3, p, 300, p, 0);
    // R4: derivative sweep with changing angle and gains
    for (int n = 0; n < 2000; n++) begin
      apply("R4", (n * 37) % 256, (n * 53) % 256, 12800, (n * 7) % 8, (n * 11) % 256);
      if (n % 50 == 0) idle_poke();
    end
    // R7: gain change while idle applies only from the next sample
    idle_poke();
    apply("R7", 10, 0, 900, 2, 3);
    // R5: first sample after a mid-run reset has no derivative
    apply("R5", 200, 0, 0, 0, 0);
    do_reset();
    check("R9", "cmd after reset", longint'(cmd_out), 0);
    apply("R5", 5, 0, 0, 0, 255);
    apply("R4", 6, 0, 0, 0, 1);
    // R6: saturation with derivative kick in both directions
    for (int n = 0; n < 64; n++) begin
      apply("R6", (n % 2) ? 255 : 0, (n % 2) ? 255 : 0, 12800, 255, 255);
      apply("R6", 128, n, 12800, n % 4, 255);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule